// File: doc/BRIEF.md
# CAN FD Transmit Format Selector

This block decides the frame format a CAN controller actually sends for a queued message. A transmit buffer element asks for a flexible-data-rate frame (FDF) and for a bit-rate switch (BRS). Two global enables filter those requests. The FD enable decides whether flexible-data-rate frames are allowed at all. The BRS enable decides whether the data phase may run at the faster rate. A classic frame can be sent under every setting.

The two enables sit in a small configuration register. It accepts a write only while the controller is in initialisation and configuration change is enabled. Writes at any other time are dropped. On every start-of-transmission pulse, the block captures three things: the filtered FDF, the filtered BRS, and the error status indicator (ESI). ESI is taken from the transmitter's error-passive flag at that moment. All three stay constant until the next pulse, so the bit serialiser downstream sees a steady frame header for the whole frame.

Top module: `canfd_txfmt`

## Requirements
- R1: After reset, both enables read as cleared and `eff_fdf`, `eff_brs` and `esi` are 0.
- R2: With the FD enable (config bit 0) cleared, a transmission starts with `eff_fdf` = 0 and `eff_brs` = 0, whatever the message requests.
- R3: With the FD enable set and the BRS enable (config bit 1) cleared, `eff_fdf` follows the message FDF and `eff_brs` is 0.
- R4: With both enables set, `eff_fdf` follows the message FDF and `eff_brs` = message FDF AND message BRS.
- R5: `eff_brs` is never 1 while `eff_fdf` is 0.
- R6: A configuration write updates the enables only when `init_mode` and `cfg_chg_en` are both 1 in the write cycle. Any other write leaves them unchanged.
- R7: `esi` equals the value of `err_passive` in the cycle of the start pulse (1 means error passive, which gives a recessive ESI).
- R8: `eff_fdf`, `eff_brs` and `esi` change only in the cycle after a start pulse and hold between pulses, even if the message inputs or `err_passive` change.
- R9: A message with FDF = 0 always produces `eff_fdf` = 0 and `eff_brs` = 0, under every enable setting.
- R10: A start pulse in the same cycle as an accepted configuration write uses the enables from before the write. The new setting applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Write data: bit 0 = FD enable, bit 1 = BRS enable |
| init_mode | input | 1 | Controller is in initialisation |
| cfg_chg_en | input | 1 | Configuration change enabled |
| msg_fdf | input | 1 | Requested FDF from the buffer element |
| msg_brs | input | 1 | Requested BRS from the buffer element |
| err_passive | input | 1 | Transmitter is error passive |
| tx_start | input | 1 | Start-of-transmission pulse |
| eff_fdf | output | 1 | Effective FDF of the current frame |
| eff_brs | output | 1 | Effective BRS of the current frame |
| esi | output | 1 | Error status indicator of the current frame |

## Verification
The enables are not visible at the ports. The hardest case is showing that a write was dropped. It is also hard to show that a write landing in the same cycle as a start pulse does not affect that frame. The stimulus tries a write under every combination of the init and change-enable inputs. After each attempt it sends messages that request both FDF and BRS, so the enable state that is actually in force appears on the effective outputs. It also lines up one accepted write with a start pulse in the same cycle, then sends a second frame, to show the order in which the two take effect.

// File: rtl/canfd_txfmt.sv
module canfd_txfmt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_wdata,
  input  logic       init_mode,
  input  logic       cfg_chg_en,
  input  logic       msg_fdf,
  input  logic       msg_brs,
  input  logic       err_passive,
  input  logic       tx_start,
  output logic       eff_fdf,
  output logic       eff_brs,
  output logic       esi
);

  logic fd_en, brs_en;
  logic cfg_open;
  logic nxt_fdf, nxt_brs;

  assign cfg_open = cfg_wr & init_mode & cfg_chg_en;
  assign nxt_fdf  = fd_en & msg_fdf;
  assign nxt_brs  = nxt_fdf & brs_en & msg_brs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd_en  <= 1'b0;
      brs_en <= 1'b0;
    end else if (cfg_open) begin
      fd_en  <= cfg_wdata[0];
      brs_en <= cfg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_fdf <= 1'b0;
      eff_brs <= 1'b0;
      esi     <= 1'b0;
    end else if (tx_start) begin
      eff_fdf <= nxt_fdf;
      eff_brs <= nxt_brs;
      esi     <= err_passive;
    end
  end

endmodule

// File: rtl/canfd_txfmt_chk.sv
module canfd_txfmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       init_mode,
  input logic       cfg_chg_en,
  input logic       msg_fdf,
  input logic       msg_brs,
  input logic       err_passive,
  input logic       tx_start,
  input logic       fd_en,
  input logic       brs_en,
  input logic       eff_fdf,
  input logic       eff_brs,
  input logic       esi
);

  p_brs_needs_fdf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eff_brs |-> eff_fdf);

  p_fd_off_classic_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !fd_en) |=> (!eff_fdf && !eff_brs));

  p_brs_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && fd_en && !brs_en) |=> (!eff_brs && eff_fdf == $past(msg_fdf)));

  p_both_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && fd_en && brs_en) |=>
      (eff_fdf == $past(msg_fdf) && eff_brs == $past(msg_fdf && msg_brs)));

  p_cfg_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && init_mode && cfg_chg_en) |=> ($stable(fd_en) && $stable(brs_en)));

  p_esi_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> (esi == $past(err_passive)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_start |=> ($stable(eff_fdf) && $stable(eff_brs) && $stable(esi)));

  p_classic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !msg_fdf) |=> !eff_fdf);

endmodule

bind canfd_txfmt canfd_txfmt_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .init_mode(init_mode),
  .cfg_chg_en(cfg_chg_en), .msg_fdf(msg_fdf), .msg_brs(msg_brs),
  .err_passive(err_passive), .tx_start(tx_start), .fd_en(fd_en),
  .brs_en(brs_en), .eff_fdf(eff_fdf), .eff_brs(eff_brs), .esi(esi)
);

// File: tb/canfd_txfmt_tb_top.sv
module canfd_txfmt_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic init_mode = 1'b0, cfg_chg_en = 1'b0;
  logic msg_fdf = 1'b0, msg_brs = 1'b0, err_passive = 1'b0, tx_start = 1'b0;
  logic eff_fdf, eff_brs, esi;

  int checks = 0, errors = 0;
  bit done = 0;
  logic m_fd = 1'b0, m_brs = 1'b0;

  always #4 clk = ~clk;

  canfd_txfmt dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .init_mode(init_mode), .cfg_chg_en(cfg_chg_en), .msg_fdf(msg_fdf),
    .msg_brs(msg_brs), .err_passive(err_passive), .tx_start(tx_start),
    .eff_fdf(eff_fdf), .eff_brs(eff_brs), .esi(esi)
  );

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual fdf/brs/esi=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] d, logic ini, logic cce);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d; init_mode = ini; cfg_chg_en = cce;
    @(negedge clk);
    cfg_wr = 1'b0; init_mode = 1'b0; cfg_chg_en = 1'b0;
    if (ini && cce) begin m_fd = d[0]; m_brs = d[1]; end
  endtask

  task automatic send(logic f, logic b, logic ep);
    @(negedge clk);
    msg_fdf = f; msg_brs = b; err_passive = ep; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  function automatic logic [2:0] model(logic f, logic b, logic ep);
    logic ef;
    ef = m_fd & f;
    return {ef, ef & m_brs & b, ep};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {eff_fdf, eff_brs, esi}, 3'b000);
    send(1'b1, 1'b1, 1'b0);
    chk("R1", {eff_fdf, eff_brs, esi}, 3'b000);

    for (int c = 0; c < 4; c++) begin
      for (int g = 0; g < 4; g++) begin
        cfg_write(c[1:0], g[1], g[0]);
        for (int m = 0; m < 8; m++) begin
          logic [2:0] e;
          string req;
          e = model(m[2], m[1], m[0]);
          send(m[2], m[1], m[0]);
          req = !m_fd ? "R2" : (!m_brs ? "R3" : "R4");
          if (g != 3) req = {req, "/R6"};
          chk(req, {eff_fdf, eff_brs, esi}, e);
          chk("R7", {2'b00, esi}, {2'b00, m[0]});
          chk("R5", {2'b00, eff_brs & ~eff_fdf}, 3'b000);
          if (!m[2]) chk("R9", {eff_fdf, eff_brs, 1'b0}, 3'b000);
          @(negedge clk);
          msg_fdf = ~msg_fdf; msg_brs = ~msg_brs; err_passive = ~err_passive;
          repeat (2) @(negedge clk);
          chk("R8", {eff_fdf, eff_brs, esi}, e);
        end
      end
    end

    cfg_write(2'b00, 1'b1, 1'b1);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 2'b11; init_mode = 1'b1; cfg_chg_en = 1'b1;
    msg_fdf = 1'b1; msg_brs = 1'b1; err_passive = 1'b1; tx_start = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; init_mode = 1'b0; cfg_chg_en = 1'b0; tx_start = 1'b0;
    chk("R10", {eff_fdf, eff_brs, esi}, 3'b001);
    send(1'b1, 1'b1, 1'b0);
    chk("R10", {eff_fdf, eff_brs, esi}, 3'b110);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule